// File: doc/BRIEF.md
# Ones-Complement Ring Lookahead Adder

This block adds two N-bit operands in ones-complement arithmetic. It does not perform a twos-complement addition and then a second pass to fold the carry back in. The end-around carry is part of the lookahead network itself.

For every bit the adder forms a generate term (operand bits ANDed) and a propagate term (operand bits ORed). The carry into each bit position is then assembled from every other position on a ring. The walk starts at the bit just below and continues downward, wrapping past the most significant bit. As a result, each output bit sees the same logic depth, and no position sits at the end of a longer chain.

The sum is captured in a single output register. It is cleared by a synchronous active-high reset. A typical use is as the combining element of a checksum datapath that works on 16-bit units, where a negative-zero result (all ones) must be kept intact.

Top module: `owc_ring_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_q` becomes all zeros after that edge, whatever the operands are.
- R2: After each rising edge with `rst` low, `sum_q` equals the ones-complement sum of the operands sampled at that edge. That sum is the low N bits of the (N+1)-bit twos-complement sum, plus that sum's bit N added into bit 0.
- R3: Adding all ones to all ones gives all ones.
- R4: Adding any value to its bitwise complement gives all ones (negative zero), with no end-around carry.
- R5: Swapping `op_a` and `op_b` does not change the registered result.
- R6: Adding zero to any operand returns that operand unchanged.
- R7: A carry generated only at the most significant bit re-enters at bit 0. For example, adding the value with only bit N-1 set to itself gives the value 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the result register |
| op_a | input | N | First addend |
| op_b | input | N | Second addend |
| sum_q | output | N | Registered ones-complement sum of the previous cycle's operands |

## Verification
The case that is hardest to reach from the ports is the longest wrapped chain: a single generate at the top bit whose carry has to cross every propagating low bit. Operand pairs built as a top-bit-set mask together with its complement over the lower bits produce exactly this, and a 16-bit instance receives such pairs for several masks. A second instance configured to 8 bits is driven with every one of the 65,536 operand pairs. This covers each possible pattern of generate and propagate terms around the ring, including every wrap distance and both zero encodings.

// File: rtl/owc_pkg.sv
package owc_pkg;
  localparam int OWC_DEFAULT_WIDTH = 16;

  // Bits j+1 .. j+len on a ring of n positions, as a 64-bit mask.
  function automatic logic [63:0] ring_span(input int j, input int len, input int n);
    logic [63:0] m;
    m = '0;
    for (int s = 1; s <= len; s++) begin
      m[(j + s) % n] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/owc_gp_stage.sv
module owc_gp_stage #(
  parameter int N = owc_pkg::OWC_DEFAULT_WIDTH
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] gen,
  output logic [N-1:0] prop
);
  always_comb begin
    gen  = a & b;
    prop = a | b;
  end
endmodule

// File: rtl/owc_ring_carry.sv
module owc_ring_carry #(
  parameter int N = owc_pkg::OWC_DEFAULT_WIDTH
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  output logic [N-1:0] cin
);
  // Each destination bit collects N terms, one per source distance on the ring.
  for (genvar i = 0; i < N; i++) begin : g_dst
    logic [N-1:0] terms;
    for (genvar k = 1; k <= N; k++) begin : g_dist
      localparam int SRC = (i - k + N) % N;
      localparam logic [63:0] SPAN = owc_pkg::ring_span(SRC, k - 1, N);
      localparam logic [N-1:0] MASK = SPAN[N-1:0];
      assign terms[k-1] = gen[SRC] & (&(prop | ~MASK));
    end
    assign cin[i] = |terms;
  end
endmodule

// File: rtl/owc_sum_stage.sv
module owc_sum_stage #(
  parameter int N = owc_pkg::OWC_DEFAULT_WIDTH
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] cin,
  output logic [N-1:0] sum
);
  always_comb sum = a ^ b ^ cin;
endmodule

// File: rtl/owc_ring_adder.sv
module owc_ring_adder #(
  parameter int N = owc_pkg::OWC_DEFAULT_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic [N-1:0] sum_q
);
  logic [N-1:0] gen, prop, cin, sum_d;

  owc_gp_stage #(.N(N)) u_gp (
    .a(op_a), .b(op_b), .gen(gen), .prop(prop)
  );

  owc_ring_carry #(.N(N)) u_ring (
    .gen(gen), .prop(prop), .cin(cin)
  );

  owc_sum_stage #(.N(N)) u_sum (
    .a(op_a), .b(op_b), .cin(cin), .sum(sum_d)
  );

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_d;
  end
endmodule

// File: rtl/owc_ring_adder_chk.sv
module owc_ring_adder_chk #(
  parameter int N = owc_pkg::OWC_DEFAULT_WIDTH
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic [N-1:0] sum_q
);
  localparam logic [N-1:0] ONES = '1;
  localparam logic [N-1:0] TOP  = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] LSB1 = {{(N-1){1'b0}}, 1'b1};

  function automatic logic [N-1:0] fold_ref(input logic [N-1:0] x, input logic [N-1:0] y);
    logic [N:0] t;
    t = {1'b0, x} + {1'b0, y};
    return t[N-1:0] + {{(N-1){1'b0}}, t[N]};
  endfunction

  // R1
  clear_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> sum_q == '0);

  // R2
  fold_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sum_q == fold_ref($past(op_a), $past(op_b)));

  // R3
  ones_plus_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (op_a == ONES && op_b == ONES) |=> sum_q == ONES);

  // R4
  neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_b == ~op_a) |=> sum_q == ONES);

  // R6
  zero_identity_chk: assert property (@(posedge clk) disable iff (rst)
    (op_b == '0) |=> sum_q == $past(op_a));

  // R7
  top_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (op_a == TOP && op_b == TOP) |=> sum_q == LSB1);
endmodule

bind owc_ring_adder owc_ring_adder_chk #(.N(N)) u_chk (.*);

// File: tb/test_owc_ring_adder.sv
module test_owc_ring_adder;
  localparam int NS = 8;
  localparam int NW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic [NS-1:0] sa, sb, sq;
  logic [NW-1:0] wa, wb, wq;
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  owc_ring_adder #(.N(NS)) i_owc_ring_adder (
    .clk(clk), .rst(rst), .op_a(sa), .op_b(sb), .sum_q(sq)
  );

  owc_ring_adder #(.N(NW)) i_owc_ring_adder_w16 (
    .clk(clk), .rst(rst), .op_a(wa), .op_b(wb), .sum_q(wq)
  );

  function automatic int fold(input int x, input int y, input int n);
    int s;
    s = x + y;
    return (s & ((1 << n) - 1)) + (s >> n);
  endfunction

  function automatic string tag_of(input int x, input int y, input int n);
    int all1;
    all1 = (1 << n) - 1;
    if (x == all1 && y == all1)                 return "R3";
    if (y == (~x & all1))                       return "R4";
    if (y == 0)                                 return "R6";
    if (x == (1 << (n-1)) && y == (1 << (n-1))) return "R7";
    return "R2";
  endfunction

  task automatic check(input string tag, input int got, input int exp, input int x, input int y);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, x, y, got, exp);
    end
  endtask

  task automatic run_small(input int x, input int y);
    sa = x[NS-1:0];
    sb = y[NS-1:0];
    @(posedge clk); #1;
    check(tag_of(x, y, NS), int'(sq), fold(x, y, NS), x, y);
  endtask

  task automatic run_wide(input int x, input int y, input string tag);
    wa = x[NW-1:0];
    wb = y[NW-1:0];
    @(posedge clk); #1;
    check(tag, int'(wq), fold(x, y, NW), x, y);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    sa = 8'h5A; sb = 8'h3C; wa = 16'hBEEF; wb = 16'h1234;
    @(posedge clk); #1;
    check("R1", int'(sq), 0, 32'h5A, 32'h3C);
    check("R1", int'(wq), 0, 32'hBEEF, 32'h1234);
    rst = 1'b0;

    // Exhaustive sweep of the 8-bit instance (R2..R7 cases all appear).
    for (int x = 0; x < (1 << NS); x++) begin
      for (int y = 0; y < (1 << NS); y++) begin
        run_small(x, y);
      end
    end

    // 16-bit corners
    run_wide(32'hFFFF, 32'hFFFF, "R3");
    run_wide(32'h1234, 32'hEDCB, "R4");
    run_wide(32'h0000, 32'hFFFF, "R4");
    run_wide(32'hA5A5, 32'h0000, "R6");
    run_wide(32'h0000, 32'h0000, "R6");
    run_wide(32'h8000, 32'h8000, "R7");
    // Longest wrapped chain: generate at the top, propagate everywhere below.
    for (int m = 0; m < 15; m++) begin
      int lo;
      lo = (1 << m) - 1;
      run_wide(32'h8000 | lo, 32'h8000 | (~lo & 32'h7FFF), "R7");
    end
    for (int r = 0; r < 2000; r++) begin
      int x, y;
      x = int'($urandom & 32'hFFFF);
      y = int'($urandom & 32'hFFFF);
      run_wide(x, y, "R2");
      run_wide(y, x, "R5");
    end

    // Reset during operation clears the register
    rst = 1'b1;
    sa = 8'hFF; sb = 8'h01; wa = 16'hFFFF; wb = 16'h0001;
    @(posedge clk); #1;
    check("R1", int'(sq), 0, 32'hFF, 32'h01);
    check("R1", int'(wq), 0, 32'hFFFF, 32'h0001);
    rst = 1'b0;
    run_wide(32'h7FFF, 32'h0001, "R2");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule